// File: doc/BRIEF.md
# Windowed Display RAM Address Generator

This block produces the column (X) and row (Y) address for a display memory while the host reads or writes a rectangular region of it. Four window registers hold the first and last column and the first and last row. A start command places both counters at the window origin. After that, each qualified host access strobe moves the column address forward by one. When the column reaches the right edge of the window, it returns to the left edge and the row moves down by one in the same clock. When the row reaches the bottom edge, it returns to the top.

One memory word is two bytes wide. In wide (16-bit) mode, each strobe covers a whole word and the column advances on every strobe. In narrow (8-bit) mode, the first strobe selects the low byte and the second selects the high byte. Only the second strobe advances the column. A byte-lane output tells the memory datapath which half is being accessed. Each mode has its own ceiling for the column, and the rows have a fixed ceiling. An edge register set above the ceiling is treated as the ceiling.

Top module: `winaddr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register clears: `x_addr`=0, `y_addr`=0, `lane_hi`=0 and all four window registers are 0.
- R2: When `win_we` is high, `win_data` is stored into the window register picked by `win_sel`: 0 = first column (low 6 bits), 1 = last column (low 6 bits), 2 = first row, 3 = last row.
- R3: In wide mode (`acc_wide16`=1), each strobe advances `x_addr` by one and leaves `lane_hi`=0.
- R4: In narrow mode (`acc_wide16`=0), a strobe with `lane_hi`=0 sets `lane_hi`=1 and leaves both addresses unchanged. A strobe with `lane_hi`=1 clears `lane_hi` and advances the column.
- R5: A column advance from a value at or above the effective last column reloads `x_addr` with the first column. In that same cycle, `y_addr` advances.
- R6: A row advance from a value at or above the effective last row reloads `y_addr` with the first row. Otherwise it adds one.
- R7: The effective last column is min(last column register, 63) in wide mode and min(register, 31) in narrow mode. The effective last row is min(last row register, 129).
- R8: With neither `acc_stb` nor `pos_load` high, `x_addr`, `y_addr` and `lane_hi` keep their values.
- R9: `pos_load` loads `x_addr` with the first column and `y_addr` with the first row, and clears `lane_hi`. It takes priority over a strobe in the same cycle, and it uses the window register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_we | input | 1 | Write enable for one window register |
| win_sel | input | 2 | Selects the window register to write |
| win_data | input | 8 | Value for the window register |
| pos_load | input | 1 | Moves both counters to the window origin |
| acc_stb | input | 1 | One host access |
| acc_wide16 | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| x_addr | output | 6 | Current column address |
| y_addr | output | 8 | Current row address |
| lane_hi | output | 1 | 1 = high byte of the word is being accessed |

## Verification
On every cycle, the assertions check the following:
- the counters and the lane hold when nothing happens;
- wide mode keeps the low lane;
- the first narrow strobe only flips the lane;
- the start command wins over a strobe and lands on the origin;
- the row moves only when the column returns to its start;
- the narrow-mode column ceiling forces a reload.

Other behaviour can only be shown by the bench's scenarios, which compare the outputs each clock with a behavioural model. This covers the full order of addresses across multiple column and row wraps, the clamping of an oversized last-row register at 129, and mode changes partway through a word. It also covers long mixed runs of window writes, strobes and start commands.

// File: rtl/winaddr_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the windowed address generator.
// Assumes: win_sel is 2 bits wide; access width is a single select bit.
package winaddr_pkg;

    // Selects which window register a write lands in.
    typedef enum logic [1:0] {
        SEL_X_FIRST = 2'd0,
        SEL_X_LAST  = 2'd1,
        SEL_Y_FIRST = 2'd2,
        SEL_Y_LAST  = 2'd3
    } win_sel_e;

    // Host access width.
    typedef enum logic {
        ACC_NARROW8 = 1'b0,
        ACC_WIDE16  = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/winaddr_regs.sv
`timescale 1ns/1ps
// Module: winaddr_regs
// Holds the four window edge registers. A write stores the low bits of the
// data bus into the register named by the select code.
// Assumes: YW <= DW and XW <= DW; synchronous active-low reset.
module winaddr_regs #(
    parameter int XW = 6,
    parameter int YW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] data,
    output logic [XW-1:0] x_first,
    output logic [XW-1:0] x_last,
    output logic [YW-1:0] y_first,
    output logic [YW-1:0] y_last
);
    import winaddr_pkg::*;

    win_sel_e sel_e;

    // Turn the raw select bits into the enum.
    always_comb sel_e = win_sel_e'(sel);

    // Update the selected edge register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_first <= '0;
            x_last  <= '0;
            y_first <= '0;
            y_last  <= '0;
        end else if (we) begin
            case (sel_e)
                SEL_X_FIRST: x_first <= data[XW-1:0];
                SEL_X_LAST:  x_last  <= data[XW-1:0];
                SEL_Y_FIRST: y_first <= data[YW-1:0];
                default:     y_last  <= data[YW-1:0];
            endcase
        end
    end
endmodule

// File: rtl/winaddr_lane.sv
`timescale 1ns/1ps
// Module: winaddr_lane
// Byte-lane tracker. In narrow mode it alternates low/high half and asks for
// a column step only on the high half. In wide mode every strobe steps.
// Assumes: a start command (clr) overrides a strobe in the same cycle.
module winaddr_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic wide,
    output logic hi,
    output logic step
);
    // Decide whether this strobe completes a word.
    always_comb step = stb && !clr && (wide || hi);

    // Track the byte half within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= 1'b0;
        end else if (clr) begin
            hi <= 1'b0;
        end else if (stb) begin
            hi <= wide ? 1'b0 : !hi;
        end
    end
endmodule

// File: rtl/winaddr_axis.sv
`timescale 1ns/1ps
// Module: winaddr_axis
// One bounded up-counter. It steps by one and reloads its start value when a
// step arrives at or above the limit. The wrap output is combinational and
// tells the next axis to step.
// Assumes: limit is already clamped by the caller; load beats step.
module winaddr_axis #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] first,
    input  logic [W-1:0] limit,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic at_edge;

    // Flag a step that must return to the window start.
    always_comb begin
        at_edge = (value >= limit);
        wrap    = step && at_edge;
    end

    // Load, step or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= first;
        end else if (step) begin
            value <= at_edge ? first : value + W'(1);
        end
    end
endmodule

// File: rtl/winaddr_gen.sv
`timescale 1ns/1ps
// Module: winaddr_gen (top)
// Windowed display memory address generator. The column advances on each
// completed word access, and it wraps to the window's left edge while the
// row advances. The row wraps to the top edge at the bottom.
// Assumes: synchronous active-low reset; the window registers are stable
// relative to pos_load in the sense that pos_load uses pre-edge values.
module winaddr_gen #(
    parameter int XW           = 6,
    parameter int YW           = 8,
    parameter int DW           = 8,
    parameter int X_MAX_WIDE   = 63,
    parameter int X_MAX_NARROW = 31,
    parameter int Y_MAX        = 129
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_we,
    input  logic [1:0]    win_sel,
    input  logic [7:0]    win_data,
    input  logic          pos_load,
    input  logic          acc_stb,
    input  logic          acc_wide16,
    output logic [5:0]    x_addr,
    output logic [7:0]    y_addr,
    output logic          lane_hi
);
    import winaddr_pkg::*;

    localparam logic [XW-1:0] XCAP_W = XW'(X_MAX_WIDE);
    localparam logic [XW-1:0] XCAP_N = XW'(X_MAX_NARROW);
    localparam logic [YW-1:0] YCAP   = YW'(Y_MAX);

    logic [XW-1:0] xs_q, xe_q, x_lim, x_cap;
    logic [YW-1:0] ys_q, ye_q, y_lim;
    logic [XW-1:0] x_val;
    logic [YW-1:0] y_val;
    logic          x_step, x_wrap, y_wrap;
    acc_mode_e     mode;

    // Name the access width.
    always_comb mode = acc_mode_e'(acc_wide16);

    winaddr_regs #(.XW(XW), .YW(YW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (win_we),
        .sel     (win_sel),
        .data    (win_data),
        .x_first (xs_q),
        .x_last  (xe_q),
        .y_first (ys_q),
        .y_last  (ye_q)
    );

    // Clamp the edge registers to the ceilings for the current mode.
    always_comb begin
        x_cap = (mode == ACC_WIDE16) ? XCAP_W : XCAP_N;
        x_lim = (xe_q > x_cap) ? x_cap : xe_q;
        y_lim = (ye_q > YCAP) ? YCAP : ye_q;
    end

    winaddr_lane u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pos_load),
        .stb   (acc_stb),
        .wide  (mode == ACC_WIDE16),
        .hi    (lane_hi),
        .step  (x_step)
    );

    winaddr_axis #(.W(XW)) u_xaxis (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pos_load),
        .step  (x_step),
        .first (xs_q),
        .limit (x_lim),
        .value (x_val),
        .wrap  (x_wrap)
    );

    winaddr_axis #(.W(YW)) u_yaxis (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pos_load),
        .step  (x_wrap),
        .first (ys_q),
        .limit (y_lim),
        .value (y_val),
        .wrap  (y_wrap)
    );

    // Drive the address ports.
    always_comb begin
        x_addr = x_val;
        y_addr = y_val;
    end

    logic unused_ok;
    // Row wrap is not needed beyond the row axis itself.
    always_comb unused_ok = y_wrap;
endmodule

// File: rtl/winaddr_gen_chk.sv
`timescale 1ns/1ps
// Module: winaddr_gen_chk
// Property checker for winaddr_gen, attached by bind.
// Assumes: the default parameters of the top (6-bit column, narrow cap 31).
module winaddr_gen_chk #(
    parameter int X_MAX_NARROW = 31
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pos_load,
    input logic       acc_stb,
    input logic       acc_wide16,
    input logic [5:0] x_addr,
    input logic [7:0] y_addr,
    input logic       lane_hi,
    input logic [5:0] xs_q,
    input logic [7:0] ys_q
);
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_stb && !pos_load) |=>
            (x_addr == $past(x_addr) && y_addr == $past(y_addr) && lane_hi == $past(lane_hi)));

    // R3
    wide_lane_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !pos_load && acc_wide16) |=> !lane_hi);

    // R4
    narrow_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !pos_load && !acc_wide16 && !lane_hi) |=>
            (lane_hi && x_addr == $past(x_addr) && y_addr == $past(y_addr)));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_load |=> (x_addr == $past(xs_q) && y_addr == $past(ys_q) && !lane_hi));

    // R5
    row_moves_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !pos_load) |=> (y_addr == $past(y_addr) || x_addr == $past(xs_q)));

    // R7
    narrow_x_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !pos_load && !acc_wide16 && lane_hi && x_addr >= 6'(X_MAX_NARROW)) |=>
            (x_addr == $past(xs_q)));
endmodule

bind winaddr_gen winaddr_gen_chk #(.X_MAX_NARROW(X_MAX_NARROW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos_load   (pos_load),
    .acc_stb    (acc_stb),
    .acc_wide16 (acc_wide16),
    .x_addr     (x_addr),
    .y_addr     (y_addr),
    .lane_hi    (lane_hi),
    .xs_q       (xs_q),
    .ys_q       (ys_q)
);

// File: tb/tb_winaddr_gen.sv
`timescale 1ns/1ps
module tb_winaddr_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_we = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic [7:0] win_data = 8'd0;
    logic       pos_load = 1'b0;
    logic       acc_stb = 1'b0;
    logic       acc_wide16 = 1'b1;
    logic [5:0] x_addr;
    logic [7:0] y_addr;
    logic       lane_hi;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Behavioural model state
    int mx = 0, my = 0, ml = 0, mxs = 0, mxe = 0, mys = 0, mye = 0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    winaddr_gen dut (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_sel(win_sel),
        .win_data(win_data), .pos_load(pos_load), .acc_stb(acc_stb),
        .acc_wide16(acc_wide16), .x_addr(x_addr), .y_addr(y_addr), .lane_hi(lane_hi)
    );

    // Reference model: advance the window counters from the requirements.
    always @(posedge clk) begin
        int xl, yl;
        if (!rst_n) begin
            mx = 0; my = 0; ml = 0; mxs = 0; mxe = 0; mys = 0; mye = 0;
        end else begin
            if (pos_load) begin
                mx = mxs; my = mys; ml = 0;
            end else if (acc_stb) begin
                if (!acc_wide16 && ml == 0) begin
                    ml = 1;
                end else begin
                    ml = 0;
                    xl = acc_wide16 ? ((mxe > 63) ? 63 : mxe) : ((mxe > 31) ? 31 : mxe);
                    yl = (mye > 129) ? 129 : mye;
                    if (mx >= xl) begin
                        mx = mxs;
                        my = (my >= yl) ? mys : my + 1;
                    end else begin
                        mx = mx + 1;
                    end
                end
            end
            if (win_we) begin
                case (win_sel)
                    2'd0: mxs = win_data % 64;
                    2'd1: mxe = win_data % 64;
                    2'd2: mys = win_data;
                    default: mye = win_data;
                endcase
            end
        end
    end

    // Compare the design with the model on every clock.
    always @(posedge clk) begin
        #5;
        if (model_on) begin
            checks++;
            if (x_addr != mx[5:0] || y_addr != my[7:0] || lane_hi != ml[0]) begin
                failures++;
                $display("FAIL R3/R4/R5/R6/R7 model compare: actual x=%0d y=%0d lane=%0d expected x=%0d y=%0d lane=%0d",
                         x_addr, y_addr, lane_hi, mx, my, ml);
            end
        end
    end

    task automatic check(input string req, input int ax, input int ay, input int al,
                         input int ex, input int ey, input int el);
        checks++;
        if (ax != ex || ay != ey || al != el) begin
            failures++;
            $display("FAIL %s: actual x=%0d y=%0d lane=%0d expected x=%0d y=%0d lane=%0d",
                     req, ax, ay, al, ex, ey, el);
        end
    endtask

    // One clock of stimulus; returns shortly after the rising edge.
    task automatic cyc(input bit we, input int sel, input int data,
                       input bit ld, input bit stb, input bit wide);
        @(negedge clk);
        win_we = we; win_sel = sel[1:0]; win_data = data[7:0];
        pos_load = ld; acc_stb = stb; acc_wide16 = wide;
        @(posedge clk);
        #2;
    endtask

    task automatic set_win(input int xs, input int xe, input int ys, input int ye);
        cyc(1, 0, xs, 0, 0, 1);
        cyc(1, 1, xe, 0, 0, 1);
        cyc(1, 2, ys, 0, 0, 1);
        cyc(1, 3, ye, 0, 0, 1);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1, 1);
        // R1: reset holds everything at zero even with a strobe
        check("R1", x_addr, y_addr, lane_hi, 0, 0, 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R2: window writes then start command
        set_win(2, 4, 10, 11);
        cyc(0, 0, 0, 1, 0, 1);
        check("R2", x_addr, y_addr, lane_hi, 2, 10, 0);

        // R3: wide strobes
        cyc(0, 0, 0, 0, 1, 1);
        check("R3", x_addr, y_addr, lane_hi, 3, 10, 0);
        cyc(0, 0, 0, 0, 1, 1);
        check("R3", x_addr, y_addr, lane_hi, 4, 10, 0);
        // R5: column wraps and row advances together
        cyc(0, 0, 0, 0, 1, 1);
        check("R5", x_addr, y_addr, lane_hi, 2, 11, 0);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 1, 1);
        // R6: row wraps to first row
        check("R6", x_addr, y_addr, lane_hi, 2, 10, 0);

        // R8: idle cycles, including a window write, hold the counters
        cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 7, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        check("R8", x_addr, y_addr, lane_hi, 2, 10, 0);
        cyc(1, 0, 2, 0, 0, 1);

        // R4: narrow mode halves
        cyc(0, 0, 0, 0, 1, 0);
        check("R4", x_addr, y_addr, lane_hi, 2, 10, 1);
        cyc(0, 0, 0, 0, 1, 0);
        check("R4", x_addr, y_addr, lane_hi, 3, 10, 0);

        // R9: start command beats a strobe in the same cycle
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 1, 0);
        check("R9", x_addr, y_addr, lane_hi, 2, 10, 0);

        // R7: narrow column ceiling of 31 with a larger last-column register
        set_win(28, 50, 5, 9);
        cyc(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 0);
        check("R7", x_addr, y_addr, lane_hi, 31, 5, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        check("R7", x_addr, y_addr, lane_hi, 28, 6, 0);
        // R7: wide mode goes past 31 up to the register value
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1);
        check("R7", x_addr, y_addr, lane_hi, 32, 6, 0);

        // R7: row ceiling 129 with last-row register 200
        set_win(0, 0, 128, 200);
        cyc(0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 0, 1, 1);
        check("R7", x_addr, y_addr, lane_hi, 0, 129, 0);
        cyc(0, 0, 0, 0, 1, 1);
        check("R6", x_addr, y_addr, lane_hi, 0, 128, 0);

        // R5: wide column wrap at 63
        set_win(60, 63, 1, 3);
        cyc(0, 0, 0, 1, 0, 1);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1);
        check("R5", x_addr, y_addr, lane_hi, 60, 2, 0);

        // Mixed random traffic compared against the model every clock
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 6, $urandom_range(0, 3), $urandom_range(0, 255),
                r >= 6 && r < 9, r >= 20, $urandom_range(0, 1));
        end

        // R1: reset mid-run clears the counters
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 1, 1);
        check("R1", x_addr, y_addr, lane_hi, 0, 0, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 1, 0, 1);
        check("R1", x_addr, y_addr, lane_hi, 0, 0, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule